// File: doc/BRIEF.md
# Prioritized Interrupt Delivery Arbiter

This block keeps one pending bit per interrupt source and, every cycle, picks the single highest-ranked source that the current machine-state enables allow to be taken. Timers, doorbells and error logic raise sources through one-cycle set strobes. Software-style clear strobes can withdraw them. While the exception entry logic is not busy, the block presents a one-hot grant and the numeric code of the chosen source. On the clock edge that ends the grant, it retires the pending bit of any source that is cleared when it is taken.

The ranking is fixed and not uniform. Each source has its own gating rule, built from the external-enable, critical-enable and hypervisor-state bits of the machine state, a hypervisor-decrementer enable, a routing bit that keeps external interrupts with the host, and a strap that says a hypervisor mode exists. Some sources are level-style and stay pending after delivery. A power-save entry strobe discards a waiting hypervisor decrementer request and marks the core as sleeping. While sleeping, the external-enable bit is treated as set, so that any enabled wake source is granted.

Top module: `intr_prio_arbiter`

## Requirements
- R1: Source indices and exception codes (`excCode` equals the index) are: 0 reset, 1 machine check, 2 hypervisor decrementer, 3 external, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable-interval timer, 9 decrementer, 10 doorbell, 11 hypervisor doorbell, 12 performance monitor, 13 thermal. Index 0 is the highest rank. Only the highest-ranked deliverable pending source is granted, `grantOh` has at most one bit set, and that bit is for a pending source.
- R2: Reset (0) and machine check (1) are deliverable whatever the enables are, and their pending bit is cleared when they are granted.
- R3: The hypervisor decrementer (2) is deliverable only when `hdecEnable`=1 and either the effective external enable is 1 or `msrHv`=0. It is cleared when granted.
- R4: External (3) is deliverable when the effective external enable is 1, or when `hvPresent`=1, `msrHv`=0 and `extKeepHost`=0. It stays pending after a grant.
- R5: Critical external (4) is deliverable only when `msrCe`=1. It stays pending after a grant.
- R6: Sources 5 to 13 are deliverable only when the effective external enable is 1. Each is cleared when granted, except as R7 states.
- R7: The decrementer (9) is cleared when granted only when `decAutoClear`=1. Otherwise it stays pending.
- R8: A `pmEnter` pulse drops a pending hypervisor decrementer and sets `inPowerSave`. While `inPowerSave`=1, the effective external enable is 1 regardless of `msrEe`. The next grant clears `inPowerSave`.
- R9: `irqReq` rises on the cycle after any set strobe. It falls only after a grant that leaves no source pending. A clear strobe alone never lowers it.
- R10: A set strobe for a source wins over a clear strobe, a delivery clear or a power-save drop of the same source in the same cycle.
- R11: While `busy`=1, no grant is issued and no pending bit is retired by delivery.
- R12: A clear strobe removes the pending bit of its source, so that source is no longer granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| setStrobe | input | 14 | One-cycle raise pulse per source |
| clrStrobe | input | 14 | One-cycle withdraw pulse per source |
| msrEe | input | 1 | External interrupt enable |
| msrCe | input | 1 | Critical interrupt enable |
| msrHv | input | 1 | Core is in hypervisor state |
| hdecEnable | input | 1 | Hypervisor decrementer enable |
| extKeepHost | input | 1 | When 0, external interrupts may bypass the external enable from guest state |
| hvPresent | input | 1 | Strap: a hypervisor mode exists |
| decAutoClear | input | 1 | Decrementer is cleared when it is granted |
| busy | input | 1 | Previous exception entry still running; grants are held off |
| pmEnter | input | 1 | Power-save entry pulse |
| grantValid | output | 1 | A grant is issued this cycle |
| grantOh | output | 14 | One-hot grant |
| excCode | output | 4 | Index of the granted source |
| irqReq | output | 1 | Interrupt request line toward the core |
| inPowerSave | output | 1 | Core is in a power-save state |

## Verification
The bench drains a full set of clear-on-grant sources one grant at a time, to show the ranking and that each bit retires. A wrong rank or a missing clear would show up as an out-of-order code or a repeated grant. It checks that the level sources (external, critical external, and the decrementer with auto-clear off) are granted again after delivery, and it walks each gating rule through both its open and its closed input combinations. A design that mixed up the hypervisor-state or routing terms would grant or hold at the wrong time. Power-save entry is tested with a hypervisor decrementer that is pending but held off. The bench then opens its gate and expects no grant, and it expects a watchdog to wake the core despite the external enable being 0. It also collides a set strobe with a grant and with a clear of the same source, which catches a design that loses the new event.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;
  localparam int SRC_COUNT = 14;
  localparam int CODE_W    = $clog2(SRC_COUNT);

  localparam int SRC_RESET = 0;
  localparam int SRC_MCHK  = 1;
  localparam int SRC_HDEC  = 2;
  localparam int SRC_EXT   = 3;
  localparam int SRC_CEXT  = 4;
  localparam int SRC_WDOG  = 5;
  localparam int SRC_DEC   = 9;

  typedef struct packed {
    logic                 grantAny;
    logic [SRC_COUNT-1:0] grantOh;
    logic [SRC_COUNT-1:0] dropOh;
  } arbStrobe_t;
endpackage

// File: rtl/intr_arb_ctrl.sv
module intr_arb_ctrl
  import intr_arb_pkg::*;
(
  input  logic [SRC_COUNT-1:0] pendVec,
  input  logic                 msrEe,
  input  logic                 msrCe,
  input  logic                 msrHv,
  input  logic                 hdecEnable,
  input  logic                 extKeepHost,
  input  logic                 hvPresent,
  input  logic                 decAutoClear,
  input  logic                 busy,
  input  logic                 inPs,
  output arbStrobe_t           strb,
  output logic [CODE_W-1:0]    excCode
);
  logic                 eeEff;
  logic [SRC_COUNT-1:0] gateVec;
  logic [SRC_COUNT-1:0] clearMask;
  logic [SRC_COUNT-1:0] candVec;
  logic [SRC_COUNT-1:0] pickOh;
  logic [CODE_W-1:0]    pickIdx;

  assign eeEff = msrEe | inPs;

  // Sources below the watchdog share one rule: gated by EE, cleared on grant.
  genvar g;
  generate
    for (g = SRC_WDOG; g < SRC_COUNT; g++) begin : gEeSrc
      assign gateVec[g] = eeEff;
      if (g == SRC_DEC) begin : gDec
        assign clearMask[g] = decAutoClear;
      end else begin : gPlain
        assign clearMask[g] = 1'b1;
      end
    end
  endgenerate

  assign gateVec[SRC_RESET] = 1'b1;
  assign gateVec[SRC_MCHK]  = 1'b1;
  assign gateVec[SRC_HDEC]  = hdecEnable & (eeEff | ~msrHv);
  assign gateVec[SRC_EXT]   = eeEff | (hvPresent & ~msrHv & ~extKeepHost);
  assign gateVec[SRC_CEXT]  = msrCe;

  assign clearMask[SRC_RESET] = 1'b1;
  assign clearMask[SRC_MCHK]  = 1'b1;
  assign clearMask[SRC_HDEC]  = 1'b1;
  assign clearMask[SRC_EXT]   = 1'b0;
  assign clearMask[SRC_CEXT]  = 1'b0;

  assign candVec = pendVec & gateVec;

  always_comb begin
    pickOh  = '0;
    pickIdx = '0;
    for (int i = SRC_COUNT - 1; i >= 0; i--) begin
      if (candVec[i]) begin
        pickOh    = '0;
        pickOh[i] = 1'b1;
        pickIdx   = CODE_W'(i);
      end
    end
  end

  always_comb begin
    strb.grantOh  = busy ? '0 : pickOh;
    strb.grantAny = |strb.grantOh;
    strb.dropOh   = strb.grantOh & clearMask;
  end

  assign excCode = strb.grantAny ? pickIdx : '0;
endmodule

// File: rtl/intr_arb_state.sv
module intr_arb_state
  import intr_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] setStrobe,
  input  logic [SRC_COUNT-1:0] clrStrobe,
  input  logic                 pmEnter,
  input  arbStrobe_t           strb,
  output logic [SRC_COUNT-1:0] pendVec,
  output logic                 inPs,
  output logic                 irqReq
);
  localparam logic [SRC_COUNT-1:0] HDEC_MASK = SRC_COUNT'(1) << SRC_HDEC;

  logic [SRC_COUNT-1:0] pmDrop;
  logic [SRC_COUNT-1:0] pendNext;

  assign pmDrop   = pmEnter ? HDEC_MASK : '0;
  assign pendNext = (pendVec & ~strb.dropOh & ~clrStrobe & ~pmDrop) | setStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendVec <= '0;
      inPs    <= 1'b0;
      irqReq  <= 1'b0;
    end else begin
      pendVec <= pendNext;
      if (pmEnter)            inPs <= 1'b1;
      else if (strb.grantAny) inPs <= 1'b0;
      if (|setStrobe)                          irqReq <= 1'b1;
      else if (strb.grantAny && pendNext == '0) irqReq <= 1'b0;
    end
  end
endmodule

// File: rtl/intr_prio_arbiter.sv
module intr_prio_arbiter
  import intr_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] setStrobe,
  input  logic [SRC_COUNT-1:0] clrStrobe,
  input  logic                 msrEe,
  input  logic                 msrCe,
  input  logic                 msrHv,
  input  logic                 hdecEnable,
  input  logic                 extKeepHost,
  input  logic                 hvPresent,
  input  logic                 decAutoClear,
  input  logic                 busy,
  input  logic                 pmEnter,
  output logic                 grantValid,
  output logic [SRC_COUNT-1:0] grantOh,
  output logic [CODE_W-1:0]    excCode,
  output logic                 irqReq,
  output logic                 inPowerSave
);
  arbStrobe_t           strb;
  logic [SRC_COUNT-1:0] pendVec;

  intr_arb_ctrl u_ctrl (
    .pendVec(pendVec), .msrEe(msrEe), .msrCe(msrCe), .msrHv(msrHv),
    .hdecEnable(hdecEnable), .extKeepHost(extKeepHost), .hvPresent(hvPresent),
    .decAutoClear(decAutoClear), .busy(busy), .inPs(inPowerSave),
    .strb(strb), .excCode(excCode)
  );

  intr_arb_state u_state (
    .clk(clk), .rstN(rstN), .setStrobe(setStrobe), .clrStrobe(clrStrobe),
    .pmEnter(pmEnter), .strb(strb), .pendVec(pendVec), .inPs(inPowerSave),
    .irqReq(irqReq)
  );

  assign grantValid = strb.grantAny;
  assign grantOh    = strb.grantOh;
endmodule

// File: rtl/intr_arb_checker.sv
module intr_arb_checker
  import intr_arb_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [SRC_COUNT-1:0] setStrobe,
  input logic                 busy,
  input logic                 pmEnter,
  input logic                 grantValid,
  input logic [SRC_COUNT-1:0] grantOh,
  input logic                 irqReq,
  input logic                 inPowerSave,
  input logic [SRC_COUNT-1:0] pendVec
);
  assert_onehot_grant_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOh) && ((grantOh & ~pendVec) == '0));

  assert_reset_retire_R2: assert property (@(posedge clk) disable iff (!rstN)
    (grantOh[SRC_RESET] && !setStrobe[SRC_RESET]) |=> !pendVec[SRC_RESET]);

  assert_ext_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    grantOh[SRC_EXT] |=> pendVec[SRC_EXT]);

  assert_cext_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    grantOh[SRC_CEXT] |=> pendVec[SRC_CEXT]);

  assert_pm_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pmEnter && !setStrobe[SRC_HDEC]) |=> (!pendVec[SRC_HDEC] && inPowerSave));

  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqReq) |-> $past(grantValid));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|setStrobe) |=> ((pendVec & $past(setStrobe)) == $past(setStrobe)));

  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !grantValid);
endmodule

bind intr_prio_arbiter intr_arb_checker u_chk (
  .clk(clk), .rstN(rstN), .setStrobe(setStrobe), .busy(busy), .pmEnter(pmEnter),
  .grantValid(grantValid), .grantOh(grantOh), .irqReq(irqReq),
  .inPowerSave(inPowerSave), .pendVec(pendVec)
);

// File: tb/test_intr_prio_arbiter.sv
`timescale 1ns/1ps
module test_intr_prio_arbiter;
  import intr_arb_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [SRC_COUNT-1:0] setStrobe = '0, clrStrobe = '0;
  logic msrEe = 0, msrCe = 0, msrHv = 0, hdecEnable = 0, extKeepHost = 0;
  logic hvPresent = 0, decAutoClear = 0, busy = 1, pmEnter = 0;
  logic grantValid, irqReq, inPowerSave;
  logic [SRC_COUNT-1:0] grantOh;
  logic [CODE_W-1:0] excCode;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  intr_prio_arbiter i_intr_prio_arbiter (
    .clk(clk), .rstN(rstN), .setStrobe(setStrobe), .clrStrobe(clrStrobe),
    .msrEe(msrEe), .msrCe(msrCe), .msrHv(msrHv), .hdecEnable(hdecEnable),
    .extKeepHost(extKeepHost), .hvPresent(hvPresent), .decAutoClear(decAutoClear),
    .busy(busy), .pmEnter(pmEnter), .grantValid(grantValid), .grantOh(grantOh),
    .excCode(excCode), .irqReq(irqReq), .inPowerSave(inPowerSave)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Open the grant path for one clock edge and check the grant shown before it.
  task automatic expectGrant(int idx, string req);
    logic [SRC_COUNT-1:0] expOh;
    busy = 1'b0;
    #1;
    expOh = (idx < 0) ? '0 : (SRC_COUNT'(1) << idx);
    check(grantValid == (idx >= 0), req, "grantValid", grantValid, idx >= 0);
    check(grantOh == expOh, req, "grantOh", grantOh, expOh);
    if (idx >= 0) check(excCode == CODE_W'(idx), req, "excCode", excCode, idx);
    @(negedge clk);
    busy = 1'b1;
  endtask

  task automatic pulseSet(logic [SRC_COUNT-1:0] m);
    setStrobe = m; @(negedge clk); setStrobe = '0;
  endtask

  task automatic pulseClr(logic [SRC_COUNT-1:0] m);
    clrStrobe = m; @(negedge clk); clrStrobe = '0;
  endtask

  function automatic logic [SRC_COUNT-1:0] bitOf(int i);
    return SRC_COUNT'(1) << i;
  endfunction

  task automatic testResetState();
    check(grantValid == 0, "R1", "reset grantValid", grantValid, 0);
    check(irqReq == 0, "R9", "reset irqReq", irqReq, 0);
    check(inPowerSave == 0, "R8", "reset inPowerSave", inPowerSave, 0);
  endtask

  task automatic testPriorityDrain();
    msrEe = 1; msrCe = 0; msrHv = 0; hdecEnable = 1; decAutoClear = 1;
    pulseSet({SRC_COUNT{1'b1}} & ~bitOf(SRC_EXT) & ~bitOf(SRC_CEXT));
    check(irqReq == 1, "R9", "irqReq after set", irqReq, 1);
    expectGrant(0, "R2");
    expectGrant(1, "R2");
    expectGrant(2, "R3");
    for (int i = SRC_WDOG; i < SRC_COUNT; i++) begin
      expectGrant(i, (i == SRC_DEC) ? "R7" : "R6");
      if (i < SRC_COUNT - 1) check(irqReq == 1, "R9", "irqReq mid drain", irqReq, 1);
    end
    expectGrant(-1, "R1");
    check(irqReq == 0, "R9", "irqReq after drain", irqReq, 0);
  endtask

  task automatic testExternal();
    msrEe = 0; msrHv = 0; hvPresent = 1; extKeepHost = 0;
    pulseSet(bitOf(SRC_EXT));
    expectGrant(SRC_EXT, "R4");
    expectGrant(SRC_EXT, "R4");
    extKeepHost = 1;
    expectGrant(-1, "R4");
    extKeepHost = 0; hvPresent = 0;
    expectGrant(-1, "R4");
    hvPresent = 1; msrHv = 1;
    expectGrant(-1, "R4");
    msrEe = 1;
    expectGrant(SRC_EXT, "R4");
    pulseClr(bitOf(SRC_EXT));
    expectGrant(-1, "R12");
    check(irqReq == 1, "R9", "irqReq after clear only", irqReq, 1);
    msrHv = 0;
  endtask

  task automatic testHdec();
    msrEe = 0; msrHv = 1; hdecEnable = 1;
    pulseSet(bitOf(SRC_HDEC));
    expectGrant(-1, "R3");
    hdecEnable = 0; msrHv = 0;
    expectGrant(-1, "R3");
    hdecEnable = 1;
    expectGrant(SRC_HDEC, "R3");
    expectGrant(-1, "R3");
    check(irqReq == 0, "R9", "irqReq after last grant", irqReq, 0);
  endtask

  task automatic testCritical();
    msrEe = 1; msrCe = 0;
    pulseSet(bitOf(SRC_CEXT));
    expectGrant(-1, "R5");
    msrCe = 1;
    expectGrant(SRC_CEXT, "R5");
    expectGrant(SRC_CEXT, "R5");
    pulseClr(bitOf(SRC_CEXT));
    expectGrant(-1, "R12");
    msrCe = 0;
  endtask

  task automatic testDecLevel();
    msrEe = 1; decAutoClear = 0;
    pulseSet(bitOf(SRC_DEC));
    expectGrant(SRC_DEC, "R7");
    expectGrant(SRC_DEC, "R7");
    msrEe = 0;
    expectGrant(-1, "R6");
    msrEe = 1;
    pulseClr(bitOf(SRC_DEC));
    expectGrant(-1, "R12");
    decAutoClear = 1;
  endtask

  task automatic testPowerSave();
    msrEe = 0; msrHv = 1; hdecEnable = 1;
    pulseSet(bitOf(SRC_HDEC) | bitOf(SRC_WDOG));
    expectGrant(-1, "R6");
    pmEnter = 1; @(negedge clk); pmEnter = 0;
    check(inPowerSave == 1, "R8", "inPowerSave set", inPowerSave, 1);
    expectGrant(SRC_WDOG, "R8");
    check(inPowerSave == 0, "R8", "inPowerSave after wake", inPowerSave, 0);
    msrHv = 0;
    expectGrant(-1, "R8");
  endtask

  task automatic testSetWins();
    msrEe = 1;
    pulseSet(bitOf(7));
    busy = 0; setStrobe = bitOf(7);
    #1;
    check(grantOh == bitOf(7), "R10", "grant during set", grantOh, bitOf(7));
    @(negedge clk);
    busy = 1; setStrobe = '0;
    expectGrant(7, "R10");
    expectGrant(-1, "R6");
    setStrobe = bitOf(8); clrStrobe = bitOf(8);
    @(negedge clk);
    setStrobe = '0; clrStrobe = '0;
    expectGrant(8, "R10");
  endtask

  task automatic testBusy();
    msrEe = 1;
    pulseSet(bitOf(SRC_RESET));
    repeat (3) begin
      #1;
      check(grantValid == 0, "R11", "grant while busy", grantValid, 0);
      @(negedge clk);
    end
    expectGrant(SRC_RESET, "R11");
    expectGrant(-1, "R2");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testPriorityDrain();
    testExternal();
    testHdec();
    testCritical();
    testDecLevel();
    testPowerSave();
    testSetWins();
    testBusy();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule